// File: doc/BRIEF.md
# Bubble-Collapsing Pipeline Register Chain

This block is a chain of `DEPTH` data registers, each with its own valid flag, that carries a payload across several clock cycles. It is used to split a long combinational computation over many stages. The producer offers a word with `in_valid` and sees `in_ready`. The consumer sees `out_valid` and answers with `out_ready`. The producer may leave idle cycles. Those idle cycles travel down the chain as empty stages. The consumer may refuse data, and the head stage then keeps its word.

While the consumer refuses data, the chain is not frozen as a whole. Any stage that has an empty stage directly after it moves its word forward. The bubbles are squeezed out this way, and the producer can keep filling the chain until every stage is occupied.

The `EDGES` parameter can add one extra register on the input side, on the output side, or on both. These registers sit outside the retimable stages. Each one behaves like a single stage of the chain.

Top module: `squeeze_pipe`

## Requirements
- R1: In the first cycle after reset is released, `out_valid` is 0 and `in_ready` is 1. Reset empties every stage.
- R2: With `out_ready` held high and no stalls, a word accepted at one clock edge appears on `out_valid`/`out_data` after exactly L edges. L is `DEPTH` plus one for each edge register. `EDGES` encodes the edge registers as 0 none, 1 input only, 2 output only, 3 both.
- R3: Every word accepted (`in_valid && in_ready` at an edge) is delivered exactly once (`out_valid && out_ready` at an edge), in the order of acceptance.
- R4: When `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1 with the same `out_data`.
- R5: `in_ready` is 0 only when every stage holds a word and the output is refused in that cycle. When the output accepts a word from a full chain, `in_ready` is 1 in that same cycle.
- R6: A cycle with `in_valid` at 0 enters nothing, whatever `in_data` holds. The number of occupied stages changes by accepted words minus delivered words.
- R7: While the output is refused, a word moves into an empty successor stage at the next edge. A chain that holds a bubble therefore still accepts words until its full capacity is reached. The capacity is `DEPTH` plus the edge registers.
- R8: With `out_ready` held high, the block accepts and delivers one word in every cycle, and `in_ready` never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Block takes the offered word at this edge |
| in_data | input | WIDTH | Offered word |
| out_valid | output | 1 | Head stage holds a word |
| out_ready | input | 1 | Consumer takes the head word at this edge |
| out_data | output | WIDTH | Head word |

## Verification
A stage whose valid flag is set or cleared wrongly shows up at the ports in one of several ways. A word may be lost. A word may be duplicated. An old word may reappear after `DEPTH` edges. The in-order scoreboard catches all of these on the first delivery that follows the fault. A broken forward-move rule cannot be hidden by a free-flowing output, because it only changes behaviour while the output is stalled. It shows as an early drop of `in_ready` during a stall, which the capacity count detects within one cycle of filling the chain. It can also show as a data change at a stalled head, which is caught at the next edge. A wrong reset or a wrong latency shows on the very first word.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;

    // Selects which optional boundary registers wrap the retimable stages.
    typedef enum logic [1:0] {
        SP_EDGE_NONE = 2'd0,
        SP_EDGE_IN   = 2'd1,
        SP_EDGE_OUT  = 2'd2,
        SP_EDGE_BOTH = 2'd3
    } sp_edge_e;

    function automatic bit sp_has_in(sp_edge_e e);
        return (e == SP_EDGE_IN) || (e == SP_EDGE_BOTH);
    endfunction

    function automatic bit sp_has_out(sp_edge_e e);
        return (e == SP_EDGE_OUT) || (e == SP_EDGE_BOTH);
    endfunction

endpackage

// File: rtl/sp_move_logic.sv
`timescale 1ns/1ps
// Decides, from head to tail, which occupied stages hand their word on.
module sp_move_logic #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] occ,
    input  logic             sink_ready,
    output logic [DEPTH-1:0] leave,
    output logic             src_ready
);

    always_comb begin
        logic room_after;
        room_after = sink_ready;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            leave[i]   = occ[i] & room_after;
            room_after = ~occ[i] | leave[i];
        end
        src_ready = room_after;
    end

endmodule

// File: rtl/sp_stage_chain.sv
`timescale 1ns/1ps
module sp_stage_chain #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] dat;
    } slot_t;

    localparam int HEAD = DEPTH - 1;

    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] leave;

    sp_move_logic #(.DEPTH(DEPTH)) u_move (
        .occ        (occ),
        .sink_ready (out_ready),
        .leave      (leave),
        .src_ready  (in_ready)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        slot_t            slot_q;
        logic             load_w;
        logic [WIDTH-1:0] src_dat;

        if (i == 0) begin : g_first
            assign load_w  = in_valid & in_ready;
            assign src_dat = in_data;
        end else begin : g_next
            assign load_w  = leave[i-1];
            assign src_dat = g_stage[i-1].slot_q.dat;
        end

        // Only the valid flag is reset; data is qualified by it.
        always_ff @(posedge clk) begin
            if (rst) slot_q.vld <= 1'b0;
            else     slot_q.vld <= load_w | (slot_q.vld & ~leave[i]);
            if (load_w) slot_q.dat <= src_dat;
        end

        assign occ[i] = slot_q.vld;
    end

    assign out_valid = g_stage[HEAD].slot_q.vld;
    assign out_data  = g_stage[HEAD].slot_q.dat;

    // Reset leaves the chain empty.
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (occ == '0));

    // Occupancy moves only by accepted and delivered words.
    assert_conserve_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(occ) ==
            $past($countones(occ)) + int'($past(in_valid & in_ready))
                                   - int'($past(out_valid & out_ready)));

    // A word never waits behind an empty successor.
    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_collapse_chk
        assert_collapse_R7: assert property (@(posedge clk) disable iff (rst)
            (occ[i] && !occ[i+1]) |=> occ[i+1]);
    end

endmodule

// File: rtl/squeeze_pipe.sv
`timescale 1ns/1ps
module squeeze_pipe
    import sp_pkg::*;
#(
    parameter int       WIDTH = 16,
    parameter int       DEPTH = 4,
    parameter sp_edge_e EDGES = SP_EDGE_NONE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    localparam bit HAS_IN  = sp_has_in(EDGES);
    localparam bit HAS_OUT = sp_has_out(EDGES);

    logic             a_valid, a_ready;
    logic [WIDTH-1:0] a_data;
    logic             b_valid, b_ready;
    logic [WIDTH-1:0] b_data;

    if (HAS_IN) begin : g_in_reg
        sp_stage_chain #(.DEPTH(1), .WIDTH(WIDTH)) u_in (
            .clk(clk), .rst(rst),
            .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
            .out_valid(a_valid), .out_ready(a_ready), .out_data(a_data)
        );
    end else begin : g_in_wire
        assign a_valid  = in_valid;
        assign a_data   = in_data;
        assign in_ready = a_ready;
    end

    sp_stage_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_core (
        .clk(clk), .rst(rst),
        .in_valid(a_valid), .in_ready(a_ready), .in_data(a_data),
        .out_valid(b_valid), .out_ready(b_ready), .out_data(b_data)
    );

    if (HAS_OUT) begin : g_out_reg
        sp_stage_chain #(.DEPTH(1), .WIDTH(WIDTH)) u_out (
            .clk(clk), .rst(rst),
            .in_valid(b_valid), .in_ready(b_ready), .in_data(b_data),
            .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
        );
    end else begin : g_out_wire
        assign out_valid = b_valid;
        assign out_data  = b_data;
        assign b_ready   = out_ready;
    end

    // A refused head keeps its word.
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // Backpressure reaches the input only through a refused, full output.
    assert_ready_room_R5: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (out_valid && !out_ready));

endmodule

// File: tb/tb_squeeze_pipe.sv
`timescale 1ns/1ps
module tb_squeeze_pipe;
    import sp_pkg::*;

    localparam int W = 16;
    localparam int CAP0 = 4;      // dut: DEPTH 4, no edge registers
    localparam int CAP1 = 3 + 2;  // dut_edges: DEPTH 3, both edge registers

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic out_ready = 1'b0;
    logic in_ready0, out_valid0, in_ready1, out_valid1;
    logic [W-1:0] out_data0, out_data1;

    int errors = 0;
    int checks = 0;
    int acc0 = 0, acc1 = 0, dlv0 = 0, dlv1 = 0;
    logic [W-1:0] exp0[$];
    logic [W-1:0] exp1[$];

    always #10 clk = ~clk;  // 50 MHz

    squeeze_pipe #(.WIDTH(W), .DEPTH(4), .EDGES(SP_EDGE_NONE)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready0),
        .in_data(in_data), .out_valid(out_valid0), .out_ready(out_ready),
        .out_data(out_data0));

    squeeze_pipe #(.WIDTH(W), .DEPTH(3), .EDGES(SP_EDGE_BOTH)) dut_edges (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready1),
        .in_data(in_data), .out_valid(out_valid1), .out_ready(out_ready),
        .out_data(out_data1));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard: R3 ordering and exactly-once delivery.
    always @(negedge clk) begin
        if (!rst) begin
            if (in_valid && in_ready0) begin exp0.push_back(in_data); acc0++; end
            if (in_valid && in_ready1) begin exp1.push_back(in_data); acc1++; end
            if (out_valid0 && out_ready) begin
                if (exp0.size() == 0) check(0, "R3", "dut extra word", int'(out_data0), -1);
                else begin
                    check(out_data0 == exp0[0], "R3", "dut order", int'(out_data0), int'(exp0[0]));
                    void'(exp0.pop_front());
                end
                dlv0++;
            end
            if (out_valid1 && out_ready) begin
                if (exp1.size() == 0) check(0, "R3", "dut_edges extra word", int'(out_data1), -1);
                else begin
                    check(out_data1 == exp1[0], "R3", "dut_edges order", int'(out_data1), int'(exp1[0]));
                    void'(exp1.pop_front());
                end
                dlv1++;
            end
        end
    end

    task automatic step(input bit v, input logic [W-1:0] d, input bit r);
        @(posedge clk); #2;
        in_valid = v; in_data = d; out_ready = r;
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) step(0, 16'hBEEF, 1);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(out_valid0 == 0, "R1", "dut out_valid after reset", out_valid0, 0);
        check(in_ready0 == 1, "R1", "dut in_ready after reset", in_ready0, 1);
        check(out_valid1 == 0, "R1", "dut_edges out_valid after reset", out_valid1, 0);
        check(in_ready1 == 1, "R1", "dut_edges in_ready after reset", in_ready1, 1);
    endtask

    task automatic t_latency;
        int lat0 = 0, lat1 = 0;
        step(1, 16'h0A11, 1);
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk); #2 in_valid = 0;
            @(negedge clk);
            if (lat0 == 0 && out_valid0) lat0 = k;
            if (lat1 == 0 && out_valid1) lat1 = k;
        end
        check(lat0 == 4, "R2", "dut latency", lat0, 4);
        check(lat1 == 5, "R2", "dut_edges latency", lat1, 5);
    endtask

    task automatic t_stream;
        int low0 = 0, low1 = 0;
        int a0 = acc0, a1 = acc1, d0 = dlv0, d1 = dlv1;
        for (int k = 0; k < 20; k++) begin
            step(1, 16'h1000 + 16'(k), 1);
            @(negedge clk);
            if (!in_ready0) low0++;
            if (!in_ready1) low1++;
        end
        drain(10);
        check(low0 == 0, "R8", "dut cycles not ready", low0, 0);
        check(low1 == 0, "R8", "dut_edges cycles not ready", low1, 0);
        check(acc0 - a0 == 20 && dlv0 - d0 == 20, "R8", "dut words through", dlv0 - d0, 20);
        check(acc1 - a1 == 20 && dlv1 - d1 == 20, "R8", "dut_edges words through", dlv1 - d1, 20);
    endtask

    task automatic t_bubbles;
        bit pat [16] = '{1,0,0,1,0,1,1,0, 1,1,0,0,0,1,0,1};
        int a0 = acc0, a1 = acc1, d0 = dlv0, d1 = dlv1;
        for (int k = 0; k < 16; k++)
            step(pat[k], pat[k] ? 16'h2000 + 16'(k) : 16'hDEAD, 1);
        drain(12);
        check(acc0 - a0 == 8, "R6", "dut accepted with bubbles", acc0 - a0, 8);
        check(acc1 - a1 == 8, "R6", "dut_edges accepted with bubbles", acc1 - a1, 8);
        check(dlv0 - d0 == 8, "R6", "dut delivered with bubbles", dlv0 - d0, 8);
        check(dlv1 - d1 == 8, "R6", "dut_edges delivered with bubbles", dlv1 - d1, 8);
    endtask

    task automatic t_stall_hold;
        logic [W-1:0] h0, h1;
        step(1, 16'h3001, 0);
        step(1, 16'h3002, 0);
        for (int k = 0; k < 8; k++) step(0, 16'hDEAD, 0);
        @(negedge clk);
        h0 = out_data0; h1 = out_data1;
        check(out_valid0 && h0 == 16'h3001, "R4", "dut stalled head", int'(h0), 16'h3001);
        check(out_valid1 && h1 == 16'h3001, "R4", "dut_edges stalled head", int'(h1), 16'h3001);
        for (int k = 0; k < 3; k++) step(0, 16'hDEAD, 0);
        @(negedge clk);
        check(out_valid0 && out_data0 == h0, "R4", "dut head held", int'(out_data0), int'(h0));
        check(out_valid1 && out_data1 == h1, "R4", "dut_edges head held", int'(out_data1), int'(h1));
        drain(10);
    endtask

    task automatic t_collapse;
        int a0 = acc0, a1 = acc1;
        step(1, 16'h4000, 0);
        step(0, 16'hDEAD, 0);
        step(0, 16'hDEAD, 0);
        for (int k = 1; k <= 9; k++) step(1, 16'h4000 + 16'(k), 0);
        @(negedge clk);
        check(acc0 - a0 == CAP0, "R7", "dut words taken while stalled", acc0 - a0, CAP0);
        check(acc1 - a1 == CAP1, "R7", "dut_edges words taken while stalled", acc1 - a1, CAP1);
        check(in_ready0 == 0, "R5", "dut ready when full and refused", in_ready0, 0);
        check(in_ready1 == 0, "R5", "dut_edges ready when full and refused", in_ready1, 0);
        step(0, 16'hDEAD, 1);
        @(negedge clk);
        check(in_ready0 == 1, "R5", "dut ready as head leaves", in_ready0, 1);
        check(in_ready1 == 1, "R5", "dut_edges ready as head leaves", in_ready1, 1);
        drain(12);
    endtask

    initial begin
        t_reset();
        t_latency();
        drain(4);
        t_stream();
        t_bubbles();
        t_stall_hold();
        t_collapse();
        check(exp0.size() == 0, "R3", "dut words left undelivered", exp0.size(), 0);
        check(exp1.size() == 0, "R3", "dut_edges words left undelivered", exp1.size(), 0);
        check(acc0 == dlv0, "R3", "dut accepted vs delivered", dlv0, acc0);
        check(acc1 == dlv1, "R3", "dut_edges accepted vs delivered", dlv1, acc1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog R1-R8 run: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule